// File: doc/BRIEF.md
# Debug Halt Control Unit

This unit records whether a processor core is stopped in debug state and manages what the rest of the core may do around it. A debug event with a cause code halts the core on the next clock. Inside the same cycle it blocks every architectural and fault register write, and it gates off the performance-monitor and trace enables. The cause code goes into a status register. If the halt came from a watchpoint, the unit also stores the matching instruction address, adjusted for the instruction-set state. While halted, the unit filters incoming exception requests: it drops most of them, and an undefined-instruction request only sets a sticky flag. A debugger restart request or a reset returns the core to normal running.

The core pipeline, the register file and the counters are not part of this block. It drives only their write enables and count enables, plus a permission line for coprocessor accesses.

Top module: `dbg_halt_ctrl`

## Requirements
- R1: One clock after `rst` is sampled high, `halted` is 0, `dsr` is all zeros and `wfar` is 0. Reset is synchronous and active high.
- R2: When `evt_valid` is high while not halted, `halted` becomes 1 on the next clock and `dsr[5:2]` takes `evt_cause`. The `dsr` bit 0 mirrors `halted`, bit 8 is the sticky undefined flag, and all other bits read 0.
- R3: `arch_we_en` and `fault_we_en` are low in every cycle where the unit is halted, and also in the cycle an entry event is accepted. In all other cycles they are high.
- R4: When an entry has cause code 4'b0010 (watchpoint), `wfar` takes `evt_addr + 8` if `isa_compact` is 0, or `evt_addr + 4` if it is 1. An entry with any other cause leaves `wfar` unchanged.
- R5: While halted, `evt_valid` has no effect: `halted`, `dsr[5:2]` and `wfar` keep their values.
- R6: `exc_take` equals `exc_req` while running and is all zeros while halted. The request bits are: bit 0 supervisor call, bit 1 undefined, bit 2 prefetch abort, bit 3 breakpoint/debug.
- R7: An undefined request (`exc_req[1]`) while halted sets `dsr[8]` on the next clock, and the unit stays halted.
- R8: `dsr[8]` is cleared only by `dbg_wr` with `dbg_wdata[8]`=1. If a clear and an undefined request while halted arrive in the same cycle, the set wins.
- R9: `pmu_evt_en`, `pmu_cyc_en` and `trc_en` are low while halted and in the cycle an entry event is accepted. In all other cycles they are high.
- R10: While halted, `cp_allow` is 1 for coprocessor numbers 14 and 15 whatever `cp_mode_ok` is. For all other numbers, and while running, `cp_allow` equals `cp_mode_ok`.
- R11: `restart` while halted clears `halted` on the next clock. In that same cycle the counter and trace enables rise, unless a new event is being accepted.
- R12: A prefetch abort request while halted is illegal and has no effect on any state or output.
- R13: A reset while halted forces an exit from debug state on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_valid | input | 1 | Debug event request |
| evt_cause | input | 4 | Cause code of the event |
| evt_addr | input | AW | Address of the instruction that hit the watchpoint |
| isa_compact | input | 1 | 1 = compressed instruction-set state |
| exc_req | input | 4 | Exception requests (see R6) |
| dbg_wr | input | 1 | Debugger write strobe to the status register |
| dbg_wdata | input | SW | Debugger write data; bit 8 = 1 clears the sticky flag |
| restart | input | 1 | Debugger restart request |
| cp_num | input | 4 | Coprocessor number of the current access |
| cp_mode_ok | input | 1 | Mode-based permission for the access |
| halted | output | 1 | Core is in debug state |
| dsr | output | SW | Debug status register |
| wfar | output | AW | Watchpoint fault address register |
| arch_we_en | output | 1 | Enable for general, status, PC and link register writes |
| fault_we_en | output | 1 | Enable for fault status and fault address register writes |
| pmu_evt_en | output | 1 | Performance event count enable |
| pmu_cyc_en | output | 1 | Cycle counter enable |
| trc_en | output | 1 | Trace port enable |
| exc_take | output | 4 | Exceptions allowed through |
| cp_allow | output | 1 | Coprocessor access permitted |

## Verification
On every cycle, the assertions check the invariants that hold while halted:
- the write enables, count enables and trace enable are low;
- the exception outputs are all zeros;
- a halt request lands on the next clock, and reset or restart ends the halt one clock later;
- the watchpoint address is captured in the 32-bit instruction state;
- no prefetch abort request arrives while halted.

Other behaviours need the bench's sweep over all sixteen cause codes and both instruction-set states:
- the exact status value after each entry;
- that the sticky flag survives a write with bit 8 at zero, and that it wins when set and clear meet in the same cycle;
- that later events leave the status and address untouched;
- the coprocessor permission for every coprocessor number.

// File: rtl/dbg_halt_pkg.sv
package dbg_halt_pkg;
    localparam int          EXC_N      = 4;
    localparam int          EXC_SVC    = 0;
    localparam int          EXC_UNDEF  = 1;
    localparam int          EXC_PABT   = 2;
    localparam int          EXC_BKPT   = 3;
    localparam int          CAUSE_W    = 4;
    localparam int          MOE_LSB    = 2;
    localparam int          STICKY_BIT = 8;
    localparam logic [3:0]  CAUSE_WATCH = 4'b0010;
    localparam logic [3:0]  CP_DEBUG    = 4'd14;
    localparam logic [3:0]  CP_SYSCTL   = 4'd15;

    typedef enum logic {ST_RUN = 1'b0, ST_HALT = 1'b1} dstate_e;

    typedef struct packed {
        logic [CAUSE_W-1:0] moe;
        logic               sticky_und;
    } stat_t;

    function automatic logic [3:0] wp_offset(input logic compact);
        return compact ? 4'd4 : 4'd8;
    endfunction
endpackage

// File: rtl/dbg_state_trk.sv
module dbg_state_trk
    import dbg_halt_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    evt_valid,
    input  logic    restart,
    output dstate_e state,
    output logic    entry
);
    dstate_e state_q;

    assign entry = (state_q == ST_RUN) && evt_valid;
    assign state = state_q;

    always_ff @(posedge clk) begin
        if (rst)
            state_q <= ST_RUN;
        else if (entry)
            state_q <= ST_HALT;
        else if (state_q == ST_HALT && restart)
            state_q <= ST_RUN;
    end
endmodule

// File: rtl/dbg_stat_reg.sv
module dbg_stat_reg
    import dbg_halt_pkg::*;
#(
    parameter int SW = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               entry,
    input  logic [CAUSE_W-1:0] cause,
    input  logic               halted,
    input  logic               undef_req,
    input  logic               clr_wr,
    input  logic               clr_bit,
    output logic [SW-1:0]      dsr
);
    stat_t st_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            if (entry)
                st_q.moe <= cause;
            if (halted && undef_req)
                st_q.sticky_und <= 1'b1;
            else if (clr_wr && clr_bit)
                st_q.sticky_und <= 1'b0;
        end
    end

    always_comb begin
        dsr                        = '0;
        dsr[0]                     = halted;
        dsr[MOE_LSB +: CAUSE_W]    = st_q.moe;
        dsr[STICKY_BIT]            = st_q.sticky_und;
    end
endmodule

// File: rtl/dbg_wp_capture.sv
module dbg_wp_capture
    import dbg_halt_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               entry,
    input  logic [CAUSE_W-1:0] cause,
    input  logic [AW-1:0]      addr,
    input  logic               compact,
    output logic [AW-1:0]      wfar
);
    logic [AW-1:0] wfar_q;
    logic [AW-1:0] adj;

    assign adj  = addr + AW'(wp_offset(compact));
    assign wfar = wfar_q;

    always_ff @(posedge clk) begin
        if (rst)
            wfar_q <= '0;
        else if (entry && cause == CAUSE_WATCH)
            wfar_q <= adj;
    end
endmodule

// File: rtl/dbg_gate.sv
module dbg_gate
    import dbg_halt_pkg::*;
(
    input  logic             halted,
    input  logic             entry,
    input  logic [EXC_N-1:0] exc_req,
    input  logic [3:0]       cp_num,
    input  logic             cp_mode_ok,
    output logic             arch_we_en,
    output logic             fault_we_en,
    output logic             pmu_evt_en,
    output logic             pmu_cyc_en,
    output logic             trc_en,
    output logic [EXC_N-1:0] exc_take,
    output logic             cp_allow
);
    logic quiet;
    logic dbg_cp;

    assign quiet  = halted || entry;
    assign dbg_cp = (cp_num == CP_DEBUG) || (cp_num == CP_SYSCTL);

    assign arch_we_en  = !quiet;
    assign fault_we_en = !quiet;
    assign pmu_evt_en  = !quiet;
    assign pmu_cyc_en  = !quiet;
    assign trc_en      = !quiet;
    assign cp_allow    = (halted && dbg_cp) ? 1'b1 : cp_mode_ok;

    for (genvar i = 0; i < EXC_N; i++) begin : g_exc
        assign exc_take[i] = exc_req[i] && !halted;
    end
endmodule

// File: rtl/dbg_halt_ctrl.sv
module dbg_halt_ctrl
    import dbg_halt_pkg::*;
#(
    parameter int AW = 32,
    parameter int SW = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             evt_valid,
    input  logic [3:0]       evt_cause,
    input  logic [AW-1:0]    evt_addr,
    input  logic             isa_compact,
    input  logic [3:0]       exc_req,
    input  logic             dbg_wr,
    input  logic [SW-1:0]    dbg_wdata,
    input  logic             restart,
    input  logic [3:0]       cp_num,
    input  logic             cp_mode_ok,
    output logic             halted,
    output logic [SW-1:0]    dsr,
    output logic [AW-1:0]    wfar,
    output logic             arch_we_en,
    output logic             fault_we_en,
    output logic             pmu_evt_en,
    output logic             pmu_cyc_en,
    output logic             trc_en,
    output logic [3:0]       exc_take,
    output logic             cp_allow
);
    dstate_e state;
    logic    entry;

    assign halted = (state == ST_HALT);

    dbg_state_trk u_state (
        .clk       (clk),
        .rst       (rst),
        .evt_valid (evt_valid),
        .restart   (restart),
        .state     (state),
        .entry     (entry)
    );

    dbg_stat_reg #(.SW(SW)) u_stat (
        .clk       (clk),
        .rst       (rst),
        .entry     (entry),
        .cause     (evt_cause),
        .halted    (halted),
        .undef_req (exc_req[EXC_UNDEF]),
        .clr_wr    (dbg_wr),
        .clr_bit   (dbg_wdata[STICKY_BIT]),
        .dsr       (dsr)
    );

    dbg_wp_capture #(.AW(AW)) u_wp (
        .clk     (clk),
        .rst     (rst),
        .entry   (entry),
        .cause   (evt_cause),
        .addr    (evt_addr),
        .compact (isa_compact),
        .wfar    (wfar)
    );

    dbg_gate u_gate (
        .halted      (halted),
        .entry       (entry),
        .exc_req     (exc_req),
        .cp_num      (cp_num),
        .cp_mode_ok  (cp_mode_ok),
        .arch_we_en  (arch_we_en),
        .fault_we_en (fault_we_en),
        .pmu_evt_en  (pmu_evt_en),
        .pmu_cyc_en  (pmu_cyc_en),
        .trc_en      (trc_en),
        .exc_take    (exc_take),
        .cp_allow    (cp_allow)
    );
endmodule

// File: rtl/dbg_halt_ctrl_chk.sv
module dbg_halt_ctrl_chk
    import dbg_halt_pkg::*;
#(
    parameter int AW = 32,
    parameter int SW = 16
) (
    input logic          clk,
    input logic          rst,
    input logic          evt_valid,
    input logic [3:0]    evt_cause,
    input logic [AW-1:0] evt_addr,
    input logic          isa_compact,
    input logic [3:0]    exc_req,
    input logic          restart,
    input logic          halted,
    input logic [SW-1:0] dsr,
    input logic [AW-1:0] wfar,
    input logic          arch_we_en,
    input logic          fault_we_en,
    input logic          pmu_evt_en,
    input logic          pmu_cyc_en,
    input logic          trc_en,
    input logic [3:0]    exc_take
);
    localparam logic [AW-1:0] OFF_WIDE = AW'(8);

    // R1 R13
    reset_exit_chk: assert property (@(posedge clk) rst |=> !halted);

    // R2
    entry_halts_chk: assert property (@(posedge clk) disable iff (rst)
        (!halted && evt_valid) |=> halted);

    // R3
    arch_block_chk: assert property (@(posedge clk) disable iff (rst)
        (halted || evt_valid) |-> (!arch_we_en && !fault_we_en));

    // R4
    wfar_wide_chk: assert property (@(posedge clk) disable iff (rst)
        (!halted && evt_valid && evt_cause == CAUSE_WATCH && !isa_compact)
        |=> (wfar == $past(evt_addr) + OFF_WIDE));

    // R5
    ignore_evt_chk: assert property (@(posedge clk) disable iff (rst)
        (halted && evt_valid && !restart) |=> (halted && $stable(dsr[MOE_LSB +: 4]) && $stable(wfar)));

    // R6
    exc_drop_chk: assert property (@(posedge clk) disable iff (rst)
        halted |-> (exc_take == '0));

    // R7
    undef_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (halted && exc_req[EXC_UNDEF] && !restart) |=> (halted && dsr[STICKY_BIT]));

    // R9
    gate_off_chk: assert property (@(posedge clk) disable iff (rst)
        halted |-> (!pmu_evt_en && !pmu_cyc_en && !trc_en));

    // R11
    restart_exit_chk: assert property (@(posedge clk) disable iff (rst)
        (halted && restart) |=> !halted);

    // R11
    regate_chk: assert property (@(posedge clk) disable iff (rst)
        ($fell(halted) && !evt_valid) |-> (pmu_evt_en && pmu_cyc_en && trc_en));

    // R12
    no_pabt_chk: assert property (@(posedge clk) disable iff (rst)
        halted |-> !exc_req[EXC_PABT]);
endmodule

bind dbg_halt_ctrl dbg_halt_ctrl_chk #(.AW(AW), .SW(SW)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .evt_valid   (evt_valid),
    .evt_cause   (evt_cause),
    .evt_addr    (evt_addr),
    .isa_compact (isa_compact),
    .exc_req     (exc_req),
    .restart     (restart),
    .halted      (halted),
    .dsr         (dsr),
    .wfar        (wfar),
    .arch_we_en  (arch_we_en),
    .fault_we_en (fault_we_en),
    .pmu_evt_en  (pmu_evt_en),
    .pmu_cyc_en  (pmu_cyc_en),
    .trc_en      (trc_en),
    .exc_take    (exc_take)
);

// File: tb/dbg_halt_ctrl_bench.sv
`timescale 1ns/1ps
module dbg_halt_ctrl_bench;
    localparam int AW = 32;
    localparam int SW = 16;

    logic          clk = 1'b0;
    logic          rst;
    logic          evt_valid;
    logic [3:0]    evt_cause;
    logic [AW-1:0] evt_addr;
    logic          isa_compact;
    logic [3:0]    exc_req;
    logic          dbg_wr;
    logic [SW-1:0] dbg_wdata;
    logic          restart;
    logic [3:0]    cp_num;
    logic          cp_mode_ok;
    logic          halted;
    logic [SW-1:0] dsr;
    logic [AW-1:0] wfar;
    logic          arch_we_en, fault_we_en, pmu_evt_en, pmu_cyc_en, trc_en;
    logic [3:0]    exc_take;
    logic          cp_allow;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    logic          m_h;
    logic [3:0]    m_moe;
    logic          m_st;
    logic [AW-1:0] m_wfar;

    always #4 clk = ~clk;

    dbg_halt_ctrl #(.AW(AW), .SW(SW)) u_dbg_halt_ctrl (
        .clk(clk), .rst(rst), .evt_valid(evt_valid), .evt_cause(evt_cause),
        .evt_addr(evt_addr), .isa_compact(isa_compact), .exc_req(exc_req),
        .dbg_wr(dbg_wr), .dbg_wdata(dbg_wdata), .restart(restart),
        .cp_num(cp_num), .cp_mode_ok(cp_mode_ok), .halted(halted), .dsr(dsr),
        .wfar(wfar), .arch_we_en(arch_we_en), .fault_we_en(fault_we_en),
        .pmu_evt_en(pmu_evt_en), .pmu_cyc_en(pmu_cyc_en), .trc_en(trc_en),
        .exc_take(exc_take), .cp_allow(cp_allow)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [SW-1:0] exp_dsr();
        logic [SW-1:0] d = '0;
        d[0]   = m_h;
        d[5:2] = m_moe;
        d[8]   = m_st;
        return d;
    endfunction

    task automatic cyc(input logic r, input logic ev, input logic [3:0] cause,
                       input logic [AW-1:0] addr, input logic cmp, input logic [3:0] er,
                       input logic wr, input logic wd8, input logic rs,
                       input logic [3:0] cpn, input logic mok);
        logic quiet;
        @(negedge clk);
        rst = r; evt_valid = ev; evt_cause = cause; evt_addr = addr;
        isa_compact = cmp; exc_req = er; dbg_wr = wr; dbg_wdata = '0;
        dbg_wdata[8] = wd8; restart = rs; cp_num = cpn; cp_mode_ok = mok;
        #1;
        if (!r) begin
            quiet = m_h || ev;
            chk("R3 arch_we_en", arch_we_en, !quiet);
            chk("R3 fault_we_en", fault_we_en, !quiet);
            chk("R9 pmu_evt_en", pmu_evt_en, !quiet);
            chk("R9 pmu_cyc_en", pmu_cyc_en, !quiet);
            chk("R9 trc_en", trc_en, !quiet);
            chk("R6 exc_take", exc_take, m_h ? 4'b0 : er);
            chk("R10 cp_allow", cp_allow, (m_h && cpn >= 4'd14) ? 1'b1 : mok);
        end
        if (r) begin
            m_h = 0; m_moe = '0; m_st = 0; m_wfar = '0;
        end else begin
            if (m_h && er[1])      m_st = 1;
            else if (wr && wd8)    m_st = 0;
            if (!m_h && ev) begin
                m_h = 1; m_moe = cause;
                if (cause == 4'b0010) m_wfar = addr + (cmp ? 32'd4 : 32'd8);
            end else if (m_h && rs) begin
                m_h = 0;
            end
        end
        @(posedge clk);
        #1;
        chk(r ? "R1 halted" : "R2 R5 R11 R13 halted", halted, m_h);
        chk(r ? "R1 dsr" : "R2 R5 R7 R8 dsr", dsr, exp_dsr());
        chk(r ? "R1 wfar" : "R4 R5 wfar", wfar, m_wfar);
    endtask

    task automatic idle();
        cyc(0, 0, 4'd0, '0, 0, 4'd0, 0, 0, 0, 4'd0, 0);
    endtask

    initial begin
        #(2_000_000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        m_h = 0; m_moe = '0; m_st = 0; m_wfar = '0;
        cyc(1, 0, 4'd0, '0, 0, 4'd0, 0, 0, 0, 4'd0, 0);
        cyc(1, 0, 4'd0, '0, 0, 4'd0, 0, 0, 0, 4'd0, 0);
        idle();
        for (int c = 0; c < 16; c++) begin
            for (int m = 0; m < 2; m++) begin
                logic [AW-1:0] a = 32'h0000_1000 + 32'(c * 64) + 32'(m * 2);
                // running: all exceptions pass, cp follows mode
                cyc(0, 0, 4'd0, '0, 0, 4'b1111, 0, 0, 0, 4'(c), m[0]);
                // R2 R4 entry
                cyc(0, 1, 4'(c), a, m[0], 4'd0, 0, 0, 0, 4'd15, 0);
                // R5 R6 events, svc and bkpt ignored while halted
                cyc(0, 1, 4'(15 - c), a + 32'h100, !m[0], 4'b1001, 0, 0, 0, 4'd14, 0);
                cyc(0, 1, 4'b0010, a + 32'h200, m[0], 4'b0001, 0, 0, 0, 4'(c), 1);
                // R7 undef sets sticky, stays halted
                cyc(0, 0, 4'd0, '0, 0, 4'b0010, 0, 0, 0, 4'd3, 0);
                // R8 write without bit 8 keeps it, with bit 8 clears
                cyc(0, 0, 4'd0, '0, 0, 4'd0, 1, 0, 0, 4'd0, 0);
                cyc(0, 0, 4'd0, '0, 0, 4'd0, 1, 1, 0, 4'd0, 0);
                // R8 set beats clear
                cyc(0, 0, 4'd0, '0, 0, 4'b0010, 1, 1, 0, 4'd0, 0);
                // R10 coprocessor sweep
                for (int n = 0; n < 16; n++)
                    cyc(0, 0, 4'd0, '0, 0, 4'd0, 0, 0, 0, 4'(n), n[0]);
                // R11 restart, then R8 clear while running
                cyc(0, 0, 4'd0, '0, 0, 4'd0, 0, 0, 1, 4'd0, 0);
                idle();
                cyc(0, 0, 4'd0, '0, 0, 4'd0, 1, 1, 0, 4'd0, 0);
            end
        end
        // R13 reset while halted
        cyc(0, 1, 4'd5, 32'h40, 0, 4'd0, 0, 0, 0, 4'd0, 0);
        cyc(1, 0, 4'd0, '0, 0, 4'd0, 0, 0, 0, 4'd0, 0);
        idle();
        // R11 restart with simultaneous new event: no re-entry this cycle
        cyc(0, 1, 4'b0010, 32'h80, 1, 4'd0, 0, 0, 0, 4'd0, 0);
        cyc(0, 1, 4'd1, 32'h90, 0, 4'd0, 0, 0, 1, 4'd0, 0);
        idle();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule